// File: doc/BRIEF.md
# Character Raster Timing Generator

This block produces the scan timing for a character-cell text display. It advances once per character clock and keeps three position counters: the character within the current scan line, the scan line within the current character row, and the character row within the frame. After the last programmed row it can insert a few extra scan lines so that the frame period can be trimmed to a fine grain. From these counters it decodes horizontal and vertical sync pulses, a display-enable window, a vertical blanking flag, a one-clock start-of-frame tick, the refresh memory address of the character being scanned and the scan line number to pass to a character generator.

All geometry values are plain inputs that are compared live against the counters, so a value changed mid-frame takes effect at the next point where that counter is compared against it. The refresh address is either a straight linear address, with each row continuing from where the previous row's visible characters ended, or a packed row/column address that puts the column in the low byte and the row number in the upper bits. An optional one-character delay of display enable allows for slow refresh memory. A synchronous active-low reset clears and holds the counters and keeps all outputs low; scanning starts at the top left of a frame on the first clock after reset is released.

Top module: `raster_timing_gen`

## Requirements
- R1: A scan line lasts `htotal`+1 character clocks, with x = 0 on the first one. `disp_en` (with `de_skew`=0) is 1 only when x < `hdisp` and the current scan line belongs to one of the first `vdisp` character rows.
- R2: `hsync` is 1 when `hsync_pos` <= x < `hsync_pos` + W, where W is `sync_widths[3:0]`. W=0 gives no pulse, and a pulse that would run past the end of the line is cut off there.
- R3: `vsync` rises at x=0 on the first scan line of row `vsync_pos` and stays high for V whole scan lines, where V is `sync_widths[7:4]`. V=0 means 16 lines.
- R4: A frame is `vtotal`+1 character rows of `max_scan`+1 scan lines each, followed by `vadjust` extra scan lines. `raster_addr` gives the scan line within the row, and it counts 0 to `vadjust`-1 during the extra lines.
- R5: With `rowcol_mode`=0, `mem_addr` = (`start_addr` + r*`hdisp` + x) mod 2^14. Here r is the row index, and r = `vtotal`+1 during the extra lines.
- R6: With `rowcol_mode`=1, `mem_addr[7:0]` = (`start_addr[7:0]` + x) mod 256 and `mem_addr[13:8]` = (`start_addr[13:8]` + r) mod 64, with r as in R5.
- R7: With `de_skew`=1, `disp_en` equals the undelayed enable of the previous character clock. It is 0 on the first clock after reset is released.
- R8: `vblank` is 1 on every scan line outside the displayed rows. It rises at x=0 of the line after the last displayed line and falls at x=0 of the first line of the next frame.
- R9: `frame_tick` is 1 for exactly one clock, the first clock of every frame, including the first frame after reset.
- R10: While `rst_n` is 0, all outputs are 0 (`hsync`, `vsync`, `disp_en`, `vblank`, `frame_tick`, `mem_addr`, `raster_addr`). The first clock after release is x=0 of scan line 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Synchronous active-low reset of counters and outputs |
| htotal | input | 8 | Characters per scan line minus one |
| hdisp | input | 8 | Visible characters per scan line |
| hsync_pos | input | 8 | Character position where hsync begins |
| sync_widths | input | 8 | [7:4] vsync lines (0 = 16), [3:0] hsync characters |
| vtotal | input | 7 | Character rows per frame minus one |
| vadjust | input | 5 | Extra scan lines appended to each frame |
| vdisp | input | 7 | Visible character rows per frame |
| vsync_pos | input | 7 | Character row where vsync begins |
| max_scan | input | 5 | Scan lines per character row minus one |
| start_addr | input | 14 | Refresh address of the top-left character |
| rowcol_mode | input | 1 | 0 linear address, 1 packed row/column address |
| de_skew | input | 1 | 1 delays display enable by one character clock |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Display enable, active high |
| vblank | output | 1 | Vertical blanking flag |
| frame_tick | output | 1 | One-clock pulse on the first clock of a frame |
| mem_addr | output | 14 | Refresh memory address |
| raster_addr | output | 5 | Scan line within the character row |

## Verification
The assertions check on every clock that the character counter steps by one and wraps after the line end, and that a completed frame restarts at row 0, line 0. They also check that the linear address rises by one between line ends, that vsync can only begin on the first line of the chosen row, and that outputs stay quiet in reset. Undelayed display enable must never coincide with blanking. The overall frame geometry, the exact sync widths including the 16-line case, the extra adjust lines, the row/column packing with its field wrap, the enable skew and the position of the frame tick can only be shown by the bench. It compares whole frames of three differently programmed configurations against a model built from the requirements.

// File: rtl/rtg_pkg.sv
// Shared widths and types for the raster timing generator.
// Assumes: the defaults below describe the standard 8/7/5/14-bit geometry.
package rtg_pkg;
    localparam int RTG_H_W    = 8;   // character counter width
    localparam int RTG_ROW_W  = 7;   // character row counter width
    localparam int RTG_LINE_W = 5;   // scan line counter width
    localparam int RTG_ADDR_W = 14;  // refresh address width
    localparam int RTG_COL_W  = 8;   // column field width in row/column mode
    localparam int RTG_SW_W   = 4;   // width of each sync-width field

    // Line-level events produced by the vertical counter.
    typedef struct packed {
        logic line_end;   // last character of a scan line
        logic row_end;    // last scan line of a character row
        logic frame_end;  // last scan line of the frame
    } rtg_step_t;
endpackage

// File: rtl/rtg_hcount.sv
// Horizontal character counter with horizontal sync and active-window decode.
// Assumes: run is 1 from the first clock after reset release; hsync_width of
// zero produces no pulse; the counter wraps only on equality with htotal.
module rtg_hcount #(
    parameter int H_W  = 8,
    parameter int SW_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [H_W-1:0]  htotal,
    input  logic [H_W-1:0]  hdisp,
    input  logic [H_W-1:0]  hsync_pos,
    input  logic [SW_W-1:0] hsync_width,
    output logic [H_W-1:0]  hc,
    output logic            line_end,
    output logic            h_active,
    output logic            hs
);
    logic [H_W:0] hs_stop;

    // Character position: steps each clock, wraps after htotal.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hc <= '0;
        else if (run)
            hc <= (hc == htotal) ? '0 : hc + 1'b1;
    end

    assign line_end = run && (hc == htotal);
    assign h_active = (hc < hdisp);

    // Sync window [hsync_pos, hsync_pos + width), computed one bit wider.
    assign hs_stop = {1'b0, hsync_pos} + (H_W+1)'(hsync_width);
    assign hs      = ({1'b0, hc} >= {1'b0, hsync_pos}) && ({1'b0, hc} < hs_stop);

    // R1
    hc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !line_end) |=> (hc == $past(hc) + 1'b1));

    // R1
    hc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hc == '0));
endmodule

// File: rtl/rtg_vcount.sv
// Vertical counters: scan line within row, character row, extra adjust lines,
// and the vertical sync line counter.
// Assumes: advances only on line_end; adjust lines hold the row at its last
// value; a vertical sync width of zero means 2**SW_W lines.
module rtg_vcount import rtg_pkg::*; #(
    parameter int ROW_W  = 7,
    parameter int LINE_W = 5,
    parameter int SW_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [ROW_W-1:0]  vtotal,
    input  logic [LINE_W-1:0] vadjust,
    input  logic [ROW_W-1:0]  vdisp,
    input  logic [ROW_W-1:0]  vsync_pos,
    input  logic [LINE_W-1:0] max_scan,
    input  logic [SW_W-1:0]   vsync_width,
    output logic [LINE_W-1:0] scan_line,
    output logic [ROW_W-1:0]  row,
    output logic              in_adjust,
    output logic              v_active,
    output logic              vs,
    output rtg_step_t         step
);
    logic [LINE_W-1:0] nxt_line;
    logic [ROW_W-1:0]  nxt_row;
    logic              nxt_adj;
    logic              row_done;
    logic              frame_done;
    logic              vs_begin;
    logic [SW_W-1:0]   vs_left;
    logic [SW_W-1:0]   vs_load;

    // Candidate position for the next scan line, with row and frame events.
    always_comb begin
        nxt_line   = scan_line + 1'b1;
        nxt_row    = row;
        nxt_adj    = in_adjust;
        row_done   = 1'b0;
        frame_done = 1'b0;
        if (in_adjust) begin
            if (scan_line == vadjust - 1'b1) begin
                frame_done = 1'b1;
                nxt_line   = '0;
                nxt_row    = '0;
                nxt_adj    = 1'b0;
            end
        end else if (scan_line == max_scan) begin
            row_done = 1'b1;
            nxt_line = '0;
            if (row == vtotal) begin
                if (vadjust == '0) begin
                    frame_done = 1'b1;
                    nxt_row    = '0;
                end else begin
                    nxt_adj = 1'b1;
                end
            end else begin
                nxt_row = row + 1'b1;
            end
        end
    end

    assign vs_begin = (nxt_row == vsync_pos) && (nxt_line == '0) && !nxt_adj;
    assign vs_load  = (vsync_width == '0) ? {SW_W{1'b1}} : vsync_width - 1'b1;

    // Position registers: load the candidate position at each line end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_line <= '0;
            row       <= '0;
            in_adjust <= 1'b0;
        end else if (line_end) begin
            scan_line <= nxt_line;
            row       <= nxt_row;
            in_adjust <= nxt_adj;
        end
    end

    // Vertical sync: start on the chosen row's first line, count lines down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vs      <= (vsync_pos == '0);
            vs_left <= vs_load;
        end else if (line_end) begin
            if (vs_begin) begin
                vs      <= 1'b1;
                vs_left <= vs_load;
            end else if (vs) begin
                if (vs_left == '0)
                    vs <= 1'b0;
                else
                    vs_left <= vs_left - 1'b1;
            end
        end
    end

    assign v_active       = !in_adjust && (row < vdisp);
    assign step.line_end  = line_end;
    assign step.row_end   = line_end && row_done;
    assign step.frame_end = line_end && frame_done;

    // R3
    vs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs) |-> (scan_line == '0 && !in_adjust && row == vsync_pos));

    // R4
    frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step.frame_end |=> (scan_line == '0 && row == '0 && !in_adjust));
endmodule

// File: rtl/rtg_addr.sv
// Refresh address generator: a linear row-base accumulator plus a row index
// for packed row/column addressing.
// Assumes: the row base latches start_addr at frame start; row/column mode
// adds the live start address field by field, each field wrapping.
module rtg_addr import rtg_pkg::*; #(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 8,
    parameter int H_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  rtg_step_t         step,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [H_W-1:0]    hdisp,
    input  logic [H_W-1:0]    hc,
    input  logic              rowcol,
    output logic [ADDR_W-1:0] addr
);
    localparam int RF_W = ADDR_W - COL_W;

    logic [ADDR_W-1:0] row_base;
    logic [RF_W-1:0]   row_idx;
    logic [ADDR_W-1:0] addr_lin;
    logic [ADDR_W-1:0] addr_rc;

    // Row start: reload at frame end, advance by the visible count per row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_base <= start_addr;
            row_idx  <= '0;
        end else if (step.frame_end) begin
            row_base <= start_addr;
            row_idx  <= '0;
        end else if (step.row_end) begin
            row_base <= row_base + ADDR_W'(hdisp);
            row_idx  <= row_idx + 1'b1;
        end
    end

    assign addr_lin = row_base + ADDR_W'(hc);
    assign addr_rc  = {start_addr[ADDR_W-1:COL_W] + row_idx,
                       start_addr[COL_W-1:0] + COL_W'(hc)};
    assign addr     = rowcol ? addr_rc : addr_lin;

    // R5
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !step.line_end) |=> (addr_lin == $past(addr_lin) + 1'b1));
endmodule

// File: rtl/raster_timing_gen.sv
// Top level of the character raster timing generator. Ties the horizontal,
// vertical and address sections together, applies the optional enable skew
// and holds every output low while reset is asserted.
// Assumes: synchronous active-low reset; geometry inputs are sampled live.
module raster_timing_gen import rtg_pkg::*; #(
    parameter int H_W    = RTG_H_W,
    parameter int ROW_W  = RTG_ROW_W,
    parameter int LINE_W = RTG_LINE_W,
    parameter int ADDR_W = RTG_ADDR_W,
    parameter int COL_W  = RTG_COL_W,
    parameter int SW_W   = RTG_SW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    htotal,
    input  logic [H_W-1:0]    hdisp,
    input  logic [H_W-1:0]    hsync_pos,
    input  logic [2*SW_W-1:0] sync_widths,
    input  logic [ROW_W-1:0]  vtotal,
    input  logic [LINE_W-1:0] vadjust,
    input  logic [ROW_W-1:0]  vdisp,
    input  logic [ROW_W-1:0]  vsync_pos,
    input  logic [LINE_W-1:0] max_scan,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              rowcol_mode,
    input  logic              de_skew,
    output logic              hsync,
    output logic              vsync,
    output logic              disp_en,
    output logic              vblank,
    output logic              frame_tick,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] raster_addr
);
    logic              run;
    logic [H_W-1:0]    hc;
    logic              line_end;
    logic              h_active;
    logic              hs;
    logic [LINE_W-1:0] scan_line;
    logic [ROW_W-1:0]  row;
    logic              in_adjust;
    logic              v_active;
    logic              vs;
    rtg_step_t         step;
    logic [ADDR_W-1:0] addr;
    logic              de_now;
    logic              de_late;

    // Scan enable: low in reset, high from the first clock after release.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run <= 1'b0;
        else
            run <= 1'b1;
    end

    rtg_hcount #(.H_W(H_W), .SW_W(SW_W)) u_h (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .htotal      (htotal),
        .hdisp       (hdisp),
        .hsync_pos   (hsync_pos),
        .hsync_width (sync_widths[SW_W-1:0]),
        .hc          (hc),
        .line_end    (line_end),
        .h_active    (h_active),
        .hs          (hs)
    );

    rtg_vcount #(.ROW_W(ROW_W), .LINE_W(LINE_W), .SW_W(SW_W)) u_v (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_end    (line_end),
        .vtotal      (vtotal),
        .vadjust     (vadjust),
        .vdisp       (vdisp),
        .vsync_pos   (vsync_pos),
        .max_scan    (max_scan),
        .vsync_width (sync_widths[2*SW_W-1:SW_W]),
        .scan_line   (scan_line),
        .row         (row),
        .in_adjust   (in_adjust),
        .v_active    (v_active),
        .vs          (vs),
        .step        (step)
    );

    rtg_addr #(.ADDR_W(ADDR_W), .COL_W(COL_W), .H_W(H_W)) u_a (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .step       (step),
        .start_addr (start_addr),
        .hdisp      (hdisp),
        .hc         (hc),
        .rowcol     (rowcol_mode),
        .addr       (addr)
    );

    assign de_now = run && h_active && v_active;

    // Skew stage: holds the previous clock's undelayed enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            de_late <= 1'b0;
        else
            de_late <= de_now;
    end

    assign disp_en     = de_skew ? de_late : de_now;
    assign hsync       = run && hs;
    assign vsync       = run && vs;
    assign vblank      = run && !v_active;
    assign frame_tick  = run && (hc == '0) && (scan_line == '0) && (row == '0) && !in_adjust;
    assign mem_addr    = run ? addr : '0;
    assign raster_addr = scan_line;

    // R10
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!hsync && !vsync && !disp_en && !vblank && !frame_tick
                    && mem_addr == '0 && raster_addr == '0));

    // R8
    de_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_en && !de_skew) |-> !vblank);

    // R9
    tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> (raster_addr == '0));
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
    localparam time TCK = 4ns;

    typedef struct {
        bit      hs;
        bit      vs;
        bit      de;
        bit      vb;
        bit      tk;
        int      ma;
        int      ra;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  htotal = '0, hdisp = '0, hsync_pos = '0, sync_widths = '0;
    logic [6:0]  vtotal = '0, vdisp = '0, vsync_pos = '0;
    logic [4:0]  vadjust = '0, max_scan = '0;
    logic [13:0] start_addr = '0;
    logic        rowcol_mode = 1'b0, de_skew = 1'b0;
    logic        hsync, vsync, disp_en, vblank, frame_tick;
    logic [13:0] mem_addr;
    logic [4:0]  raster_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t exp_q[$];

    // model configuration
    int g_ht, g_hd, g_hp, g_hw, g_vw, g_vt, g_va, g_vd, g_vp, g_ms, g_start;
    bit g_rc, g_skew;

    raster_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .htotal(htotal), .hdisp(hdisp),
        .hsync_pos(hsync_pos), .sync_widths(sync_widths), .vtotal(vtotal),
        .vadjust(vadjust), .vdisp(vdisp), .vsync_pos(vsync_pos),
        .max_scan(max_scan), .start_addr(start_addr), .rowcol_mode(rowcol_mode),
        .de_skew(de_skew), .hsync(hsync), .vsync(vsync), .disp_en(disp_en),
        .vblank(vblank), .frame_tick(frame_tick), .mem_addr(mem_addr),
        .raster_addr(raster_addr)
    );

    always #(TCK/2) clk = ~clk;

    task automatic chk(input string tag, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, name, act, exp);
        end
    endtask

    // Undelayed enable expected at cycle t after reset release (R1).
    function automatic bit raw_de(int t);
        int h, rows, vdc, line, x;
        if (t < 0) return 0;
        h    = g_ht + 1;
        rows = g_vt + 1;
        vdc  = (g_vd < rows) ? g_vd : rows;
        line = (t / h) % (rows * (g_ms + 1) + g_va);
        x    = t % h;
        return (x < g_hd) && (line < vdc * (g_ms + 1));
    endfunction

    function automatic exp_t model(int t);
        exp_t e;
        int h, rows, rl, lpf, line, x, r, vdc, vwid, s;
        h    = g_ht + 1;
        rows = g_vt + 1;
        rl   = rows * (g_ms + 1);
        lpf  = rl + g_va;
        line = (t / h) % lpf;
        x    = t % h;
        vdc  = (g_vd < rows) ? g_vd : rows;
        r    = (line < rl) ? line / (g_ms + 1) : rows;
        vwid = (g_vw == 0) ? 16 : g_vw;
        s    = g_vp * (g_ms + 1);
        e.hs = (x >= g_hp) && (x < g_hp + g_hw);
        e.vs = (line >= s) && (line < s + vwid);
        e.de = g_skew ? raw_de(t - 1) : raw_de(t);
        e.vb = !(line < vdc * (g_ms + 1));
        e.tk = (t % (h * lpf)) == 0;
        e.ra = (line < rl) ? line % (g_ms + 1) : line - rl;
        if (g_rc)
            e.ma = ((((g_start >> 8) + r) % 64) << 8) | (((g_start & 255) + x) % 256);
        else
            e.ma = (g_start + r * g_hd + x) % 16384;
        return e;
    endfunction

    // Monitor: pop one expected item per clock and compare just after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                chk("R2", "hsync", int'(hsync), int'(e.hs));
                chk("R3", "vsync", int'(vsync), int'(e.vs));
                chk(g_skew ? "R7" : "R1", "disp_en", int'(disp_en), int'(e.de));
                chk("R8", "vblank", int'(vblank), int'(e.vb));
                chk("R9", "frame_tick", int'(frame_tick), int'(e.tk));
                chk(g_rc ? "R6" : "R5", "mem_addr", int'(mem_addr), e.ma);
                chk("R4", "raster_addr", int'(raster_addr), e.ra);
            end
        end
    end

    // Driver: program a case under reset, check the quiet state, then push a
    // model item for every scanned clock.
    task automatic run_case(int ht, int hd, int hp, int hw, int vw, int vt, int va,
                            int vd, int vp, int ms, int st, bit rc, bit sk, int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        g_ht = ht; g_hd = hd; g_hp = hp; g_hw = hw; g_vw = vw; g_vt = vt;
        g_va = va; g_vd = vd; g_vp = vp; g_ms = ms; g_start = st; g_rc = rc; g_skew = sk;
        htotal = 8'(ht); hdisp = 8'(hd); hsync_pos = 8'(hp);
        sync_widths = {4'(vw), 4'(hw)};
        vtotal = 7'(vt); vadjust = 5'(va); vdisp = 7'(vd); vsync_pos = 7'(vp);
        max_scan = 5'(ms); start_addr = 14'(st); rowcol_mode = rc; de_skew = sk;
        repeat (3) @(negedge clk);
        // R10: quiet outputs while reset is held
        chk("R10", "hsync in reset", int'(hsync), 0);
        chk("R10", "vsync in reset", int'(vsync), 0);
        chk("R10", "disp_en in reset", int'(disp_en), 0);
        chk("R10", "vblank in reset", int'(vblank), 0);
        chk("R10", "frame_tick in reset", int'(frame_tick), 0);
        chk("R10", "mem_addr in reset", int'(mem_addr), 0);
        chk("R10", "raster_addr in reset", int'(raster_addr), 0);
        rst_n = 1'b1;
        exp_q.push_back(model(0));
        for (int t = 1; t < ncyc; t++) begin
            @(negedge clk);
            exp_q.push_back(model(t));
        end
        @(negedge clk);
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    initial begin
        // linear mode, adjust lines, address wrap past 14 bits
        run_case(11, 8, 9, 2, 2, 3, 2, 3, 3, 2, 16'h3FF0, 1'b0, 1'b0, 400);
        // row/column mode, skewed enable, full-width line, 16-line vsync, cut hsync
        run_case(9, 10, 8, 5, 0, 5, 0, 4, 1, 3, 16'h2AF8, 1'b1, 1'b1, 500);
        // single-line rows, vsync on row 0, no hsync, all rows displayed
        run_case(5, 3, 2, 0, 1, 4, 3, 5, 0, 0, 5, 1'b0, 1'b0, 150);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", "hsync after final reset", int'(hsync), 0);
        chk("R10", "mem_addr after final reset", int'(mem_addr), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(TCK * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule